// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Controller

This block drives two independent pulse-width outputs from a small 32-bit register bus. Each channel picks one of four clock-source strobes, divides the chosen strobe by a programmable ratio and gates the result with its own clock-gate bit. The resulting count tick drives a waveform generator. Each period holds the output high for a programmed number of ticks and then low for a second programmed number, and then repeats.

Software packs both phase lengths of a channel into one count word. The source selects, dividers, clock gates and output enables of both channels share one control word. The clock sources are not real clocks. They are single-cycle strobes in the system clock domain, and the whole block runs on that one clock, using clock enables.

Top module: `dual_pwm_ctrl`

## Requirements
- R1: After a synchronous reset, all three registers read as zero and both outputs are low.
- R2: Byte offset 0x0 holds channel A's count word, 0x4 holds channel B's and 0x8 holds the control word. Each reads back exactly what was written, one cycle after the address is presented, and holds its value when no write targets it.
- R3: In a count word, bits [31:16] give the high-phase length and bits [15:0] give the low-phase length, both in ticks. Each period starts with its high phase and then runs its low phase.
- R4: A divider field value N gives one tick per N+1 strobes of the selected source. The field is control bits [14:8] for A and [22:16] for B.
- R5: Control bits [5:4] (A) and [7:6] (B) pick which of the four `src_tick` lines feeds the channel's divider. A value of k selects `src_tick[k]`.
- R6: Control bit 15 (A) and bit 23 (B) gate the tick. While the gate bit is clear, no tick occurs and the output holds its level.
- R7: Control bit 0 enables output A and bit 1 enables output B. Clearing an enable drives that output low on the next clock, without waiting for the period to end.
- R8: A high length of zero keeps the output low, and a low length of zero keeps it high.
- R9: A channel samples its count word only at the start of each period, so a write during a period takes effect from the following period.
- R10: The two channels run concurrently with unrelated settings, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Clock-source strobes, one per selectable source |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| pwm_out | output | 2 | Registered PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
On every cycle, the assertions check several properties. A cleared enable forces its output low on the next clock. A closed gate suppresses ticks. A nonzero divider never produces back-to-back ticks. The position inside a running period stays below the latched period length. A period with zero high length shows a low output. The control word changes only under a write.

The following can only be shown by the bench's scenarios, which measure high and low run lengths on the output pins against values computed from the settings:
- the exact phase lengths and their order
- the divide ratio
- the source selection
- the deferral of a mid-period count update to the next period
- the independence of two channels running together

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int SEL_W  = 2;
  localparam int SRC_N  = 1 << SEL_W;
  localparam int CH_N   = 2;
  localparam int POS_W  = CNT_W + 1;

  typedef struct packed {
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    logic [SEL_W-1:0] src_sel;
    logic [DIV_W-1:0] div;
    logic             gate;
    logic             en;
  } ch_cfg_t;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output ch_cfg_t           cfg [CH_N]
);
  localparam logic [ADDR_W-1:0] OFS_A    = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_B    = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4'h8);

  logic [31:0] cnt_q [CH_N];
  logic [31:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
      ctrl_q   <= '0;
      rdata    <= '0;
    end else begin
      if (we) begin
        if (addr == OFS_A)    cnt_q[0] <= wdata;
        if (addr == OFS_B)    cnt_q[1] <= wdata;
        if (addr == OFS_CTRL) ctrl_q   <= wdata;
      end
      if (addr == OFS_A)         rdata <= cnt_q[0];
      else if (addr == OFS_B)    rdata <= cnt_q[1];
      else if (addr == OFS_CTRL) rdata <= ctrl_q;
      else                       rdata <= '0;
    end
  end

  // Field positions are fixed by the register layout.
  always_comb begin
    cfg[0].hi_len  = cnt_q[0][31:16];
    cfg[0].lo_len  = cnt_q[0][15:0];
    cfg[0].en      = ctrl_q[0];
    cfg[0].src_sel = ctrl_q[5:4];
    cfg[0].div     = ctrl_q[14:8];
    cfg[0].gate    = ctrl_q[15];
    cfg[1].hi_len  = cnt_q[1][31:16];
    cfg[1].lo_len  = cnt_q[1][15:0];
    cfg[1].en      = ctrl_q[1];
    cfg[1].src_sel = ctrl_q[7:6];
    cfg[1].div     = ctrl_q[22:16];
    cfg[1].gate    = ctrl_q[23];
  end

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctrl_q));
endmodule

// File: rtl/dpwm_tick.sv
module dpwm_tick
  import dpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic             gate,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_cnt;
  logic             src;
  logic             wrap;

  assign src  = src_tick[sel];
  assign wrap = (div_cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || !gate) begin
      div_cnt <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= src && wrap;
      if (src) div_cnt <= wrap ? '0 : div_cnt + 1'b1;
    end
  end

  assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !tick_o);
  assert_no_double_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div != '0) |=> !tick_o);
endmodule

// File: rtl/dpwm_wave.sv
module dpwm_wave
  import dpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_cfg,
  input  logic [CNT_W-1:0] lo_cfg,
  output logic             pwm_o
);
  logic [CNT_W-1:0] hi_q, lo_q;
  logic [POS_W-1:0] pos, total_q, total_cfg;
  logic             start_q;

  assign total_cfg = POS_W'(hi_cfg) + POS_W'(lo_cfg);
  assign total_q   = POS_W'(hi_q) + POS_W'(lo_q);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pwm_o   <= 1'b0;
      pos     <= '0;
      start_q <= 1'b1;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (tick) begin
      if (start_q) begin
        hi_q    <= hi_cfg;
        lo_q    <= lo_cfg;
        pwm_o   <= (hi_cfg != '0);
        pos     <= POS_W'(1);
        start_q <= (total_cfg <= POS_W'(1));
      end else begin
        pwm_o   <= (pos < POS_W'(hi_q));
        pos     <= pos + 1'b1;
        start_q <= (pos + 1'b1 == total_q);
      end
    end
  end

  assert_disable_low_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o);
  assert_pos_bound_R3: assert property (@(posedge clk) disable iff (rst)
    !start_q |-> (pos < total_q));
  assert_zero_high_low_R8: assert property (@(posedge clk) disable iff (rst)
    (!start_q && hi_q == '0) |-> !pwm_o);
endmodule

// File: rtl/dual_pwm_ctrl.sv
module dual_pwm_ctrl
  import dpwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  src_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [CH_N-1:0]   pwm_out
);
  ch_cfg_t cfg [CH_N];

  dpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cfg(cfg)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic tick;
    dpwm_tick u_tick (
      .clk(clk), .rst(rst), .src_tick(src_tick),
      .sel(cfg[c].src_sel), .div(cfg[c].div), .gate(cfg[c].gate),
      .tick_o(tick)
    );
    dpwm_wave u_wave (
      .clk(clk), .rst(rst), .en(cfg[c].en), .tick(tick),
      .hi_cfg(cfg[c].hi_len), .lo_cfg(cfg[c].lo_len),
      .pwm_o(pwm_out[c])
    );
  end
endmodule

// File: tb/tb_dual_pwm_ctrl.sv
module tb_dual_pwm_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = 4'b0001;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Expected runs: level * 1_000_000 + length in clocks.
  int  q0 [$];
  int  q1 [$];
  bit  armed [2] = '{0, 0};
  bit  arm_req [2] = '{0, 0};
  logic last [2] = '{1'b0, 1'b0};
  int  run [2] = '{0, 0};

  dual_pwm_ctrl dut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  always @(negedge clk) src_tick[2] <= ~src_tick[2];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Monitor: measures run lengths and compares against the scoreboard.
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      logic cur;
      cur = pwm_out[c];
      if (rst) begin
        run[c] = 0;
        last[c] = cur;
      end else if (cur != last[c]) begin
        if (armed[c]) begin
          int got, exp;
          got = (last[c] ? 1000000 : 0) + run[c];
          if (c == 0 && q0.size() > 0) begin
            exp = q0.pop_front();
            check(got == exp, "R3 ch A run", got, exp);
            if (q0.size() == 0) armed[c] = 0;
          end else if (c == 1 && q1.size() > 0) begin
            exp = q1.pop_front();
            check(got == exp, "R3 ch B run", got, exp);
            if (q1.size() == 0) armed[c] = 0;
          end
        end else if (arm_req[c] && cur) begin
          armed[c] = 1;
          arm_req[c] = 0;
        end
        run[c] = 1;
        last[c] = cur;
      end else begin
        run[c]++;
      end
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic push(input int c, input int lvl, input int len);
    if (c == 0) q0.push_back(lvl * 1000000 + len);
    else        q1.push_back(lvl * 1000000 + len);
  endtask

  task automatic drain();
    while (arm_req[0] || arm_req[1] || armed[0] || armed[1]) @(negedge clk);
  endtask

  task automatic hold_level(input int c, input logic lvl, input int n, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[c] !== lvl) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(pwm_out == 2'b00, "R1 outputs", pwm_out, 0);
    bus_read(4'h0, rd); check(rd == 0, "R1 count A", rd, 0);
    bus_read(4'h4, rd); check(rd == 0, "R1 count B", rd, 0);
    bus_read(4'h8, rd); check(rd == 0, "R1 control", rd, 0);

    // R2: readback at each offset
    bus_write(4'h0, 32'h1234_5678);
    bus_write(4'h4, 32'h9abc_def0);
    bus_write(4'h8, 32'h00A5_5A00);
    bus_read(4'h0, rd); check(rd == 32'h1234_5678, "R2 count A", rd, 32'h1234_5678);
    bus_read(4'h4, rd); check(rd == 32'h9abc_def0, "R2 count B", rd, 32'h9abc_def0);
    bus_read(4'h8, rd); check(rd == 32'h00A5_5A00, "R2 control", rd, 32'h00A5_5A00);
    bus_write(4'h8, 0);

    // R3: high 3, low 5, divider 0, source 0
    bus_write(4'h0, 32'h0003_0005);
    push(0, 1, 3); push(0, 0, 5); push(0, 1, 3); push(0, 0, 5);
    arm_req[0] = 1;
    bus_write(4'h8, 32'h0000_8001);
    drain();
    bus_write(4'h8, 0);

    // R4: divider 2 -> tick every 3 clocks
    push(0, 1, 9); push(0, 0, 15); push(0, 1, 9);
    arm_req[0] = 1;
    bus_write(4'h8, 32'h0000_8201);
    drain();
    bus_write(4'h8, 0);

    // R5: source 2 (strobe every 2 clocks)
    push(0, 1, 6); push(0, 0, 10); push(0, 1, 6);
    arm_req[0] = 1;
    bus_write(4'h8, 32'h0000_8021);
    drain();
    bus_write(4'h8, 0);

    // R9: new counts wait for the next period
    bus_write(4'h0, 32'h0008_0004);
    push(0, 1, 8); push(0, 0, 4); push(0, 1, 2); push(0, 0, 6); push(0, 1, 2);
    arm_req[0] = 1;
    bus_write(4'h8, 32'h0000_8001);
    while (!armed[0]) @(negedge clk);
    bus_write(4'h0, 32'h0002_0006);
    drain();
    bus_write(4'h8, 0);

    // R10: both channels together, B with divider 1
    bus_write(4'h0, 32'h0003_0005);
    bus_write(4'h4, 32'h0004_0002);
    push(0, 1, 3); push(0, 0, 5); push(0, 1, 3);
    push(1, 1, 8); push(1, 0, 4); push(1, 1, 8);
    arm_req[0] = 1; arm_req[1] = 1;
    bus_write(4'h8, 32'h0081_8003);
    drain();
    bus_write(4'h8, 0);

    // R8: zero high length stays low
    bus_write(4'h0, 32'h0000_0007);
    bus_write(4'h8, 32'h0000_8001);
    hold_level(0, 1'b0, 60, "R8 zero high");

    // R8: zero low length stays high
    bus_write(4'h0, 32'h0007_0000);
    repeat (4) @(negedge clk);
    hold_level(0, 1'b1, 60, "R8 zero low");

    // R6: closing the gate freezes the level
    bus_write(4'h8, 32'h0000_0001);
    hold_level(0, 1'b1, 40, "R6 gate freeze");

    // R7: clearing the enable drops the output on the next clock
    bus_write(4'h8, 32'h0000_0000);
    @(negedge clk);
    check(pwm_out[0] == 1'b0, "R7 immediate low", pwm_out[0], 0);

    // R6: gate closed from the start, no waveform appears
    bus_write(4'h0, 32'h0003_0005);
    bus_write(4'h8, 32'h0000_0001);
    hold_level(0, 1'b0, 50, "R6 no ticks");

    // R7: channel B stays low while only A is enabled
    bus_write(4'h8, 32'h0000_8001);
    hold_level(1, 1'b0, 40, "R7 B disabled");
    bus_write(4'h8, 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule